// File: doc/BRIEF.md
# TDM Time-Slot Router

This block splits a time-division multiplexed serial frame among several internal serial channels. For each slot it decides which channel owns it, or that no channel does. The assignment is held as a run-length list. Every list entry pairs a run length, meaning how many consecutive slots it covers, with a destination code. The block walks this list once per frame and advances one slot on every slot strobe. A strobe that carries a frame-start mark rewinds the walk to the first entry.

Transmit and receive each have their own list, list length register and walker, and they run independently. A single write port programs both lists while the router is disabled. Each direction reports the destination code of the slot in progress, which is held until the next slot strobe. It also gives a one-cycle per-channel pulse that marks the start of a slot owned by that channel.

Top module: `tdm_slot_router`

## Requirements
- R1: After reset, and for as long as `enable` is low, every `*_dest` output is 0 and every `*_valid` bit is 0. After reset each list holds one valid entry (run 1, destination 0) in every position, and the list length is 1.
- R2: An entry holds a run length from 1 to 64, written as its plain binary value on `wr_count`, and a destination from 0 to 5 on `wr_dest`. Destination 0 means the slot is unused: the output reads 0 and no valid bit pulses. Destination d from 1 to 5 selects channel d.
- R3: A slot strobe that comes with a frame-start strobe uses entry 0 for that slot and restarts the walk from there, even in the middle of a frame.
- R4: The entries cover contiguous slot ranges in list order. Entry k owns the slots that follow those of entries 0 to k-1. The edge that samples a slot strobe loads that slot's destination into `*_dest`, where it holds until the next strobe. The same edge raises `*_valid` bit d-1 for exactly one cycle when the destination d is non-zero.
- R5: The slots after the last valid entry (index length-1) are unused until the next frame start. Slots seen after enabling but before the first frame start are also unused.
- R6: A write with `wr_en` high is accepted only while `enable` is low. Writes made while enabled leave the list and the length unchanged.
- R7: An entry write is rejected if `wr_flags` is non-zero, if the run length is 0 or above 64, or if the destination is above 5. A length write (`wr_kind`=1) is rejected if `wr_len` is 0 or above 64. An entry write uses `wr_kind`=0.
- R8: `wr_dir`=0 selects the transmit list and `wr_dir`=1 the receive list. The two directions' lists, strobes and outputs do not affect each other.
- R9: A frame-start strobe without a slot strobe in the same cycle is ignored.
- R10: Each `*_valid` vector has at most one bit set, and only in the cycle right after a slot strobe was sampled while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Router run enable; low locks nothing out but clears walkers |
| tx_slot_stb | input | 1 | Transmit slot boundary strobe |
| tx_frame_stb | input | 1 | Transmit frame-start mark, qualified by tx_slot_stb |
| rx_slot_stb | input | 1 | Receive slot boundary strobe |
| rx_frame_stb | input | 1 | Receive frame-start mark, qualified by rx_slot_stb |
| wr_en | input | 1 | Table write request |
| wr_dir | input | 1 | 0 transmit list, 1 receive list |
| wr_kind | input | 1 | 0 entry write, 1 list length write |
| wr_addr | input | 6 | Entry index |
| wr_count | input | 7 | Run length of the entry |
| wr_dest | input | 3 | Destination code of the entry |
| wr_flags | input | 4 | Reserved flags, must be zero |
| wr_len | input | 7 | Number of valid entries |
| tx_dest | output | 3 | Destination of the current transmit slot |
| tx_valid | output | 5 | Per-channel transmit slot pulse |
| rx_dest | output | 3 | Destination of the current receive slot |
| rx_valid | output | 5 | Per-channel receive slot pulse |

## Verification
A walker whose entry pointer or run counter is off by one shows up as a wrong `*_dest` on the first slot after an entry boundary, one cycle after that slot's strobe. So a contiguous multi-entry frame exposes it within one frame. A stale pointer after a frame-start mark shows on the very next slot as a destination other than entry 0's. A walker that fails to stop at the list length shows as a non-zero destination on the first slot past the last entry. A table write that slips through the lock or the field checks stays hidden until the next frame reaches that entry, so the bench runs a full frame after each rejected write.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
   typedef enum logic {
      WR_ENTRY  = 1'b0,
      WR_LENGTH = 1'b1
   } wr_kind_e;

   localparam int DIR_TX = 0;
   localparam int DIR_RX = 1;
   localparam int N_DIR  = 2;
endpackage

// File: rtl/tsr_route_table.sv
module tsr_route_table #(
   parameter int MAX_ENTRIES = 64,
   parameter int MAX_RUN     = 64,
   parameter int N_CHAN      = 5,
   parameter int FLAG_W      = 4,
   localparam int IDX_W  = $clog2(MAX_ENTRIES),
   localparam int RUN_W  = $clog2(MAX_RUN + 1),
   localparam int LEN_W  = $clog2(MAX_ENTRIES + 1),
   localparam int DEST_W = $clog2(N_CHAN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              wr_en_i,
   input  logic              wr_kind_i,
   input  logic [IDX_W-1:0]  wr_addr_i,
   input  logic [RUN_W-1:0]  wr_count_i,
   input  logic [DEST_W-1:0] wr_dest_i,
   input  logic [FLAG_W-1:0] wr_flags_i,
   input  logic [LEN_W-1:0]  wr_len_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [RUN_W-1:0]  rd_count_o,
   output logic [DEST_W-1:0] rd_dest_o,
   output logic [IDX_W-1:0]  last_idx_o
);
   import tsr_pkg::*;

   logic [RUN_W-1:0]  count_q [MAX_ENTRIES];
   logic [DEST_W-1:0] dest_q  [MAX_ENTRIES];
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  len_m1;

   logic entry_ok, len_ok;

   always_comb begin
      entry_ok = wr_en_i && !enable_i && (wr_kind_i == WR_ENTRY)
              && (wr_flags_i == '0)
              && (wr_count_i != '0)
              && (wr_count_i <= RUN_W'(MAX_RUN))
              && (wr_dest_i <= DEST_W'(N_CHAN))
              && ({1'b0, wr_addr_i} < (IDX_W+1)'(MAX_ENTRIES));
      len_ok   = wr_en_i && !enable_i && (wr_kind_i == WR_LENGTH)
              && (wr_len_i != '0)
              && (wr_len_i <= LEN_W'(MAX_ENTRIES));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MAX_ENTRIES; i++) begin
            count_q[i] <= RUN_W'(1);
            dest_q[i]  <= '0;
         end
         len_q <= LEN_W'(1);
      end else begin
         if (entry_ok) begin
            count_q[wr_addr_i] <= wr_count_i;
            dest_q[wr_addr_i]  <= wr_dest_i;
         end
         if (len_ok) len_q <= wr_len_i;
      end
   end

   assign len_m1     = len_q - LEN_W'(1);
   assign last_idx_o = len_m1[IDX_W-1:0];
   assign rd_count_o = count_q[rd_idx_i];
   assign rd_dest_o  = dest_q[rd_idx_i];

   AST_LEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      enable_i |=> $stable(len_q)); // R6
   AST_ENTRY0_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      enable_i |=> ($stable(count_q[0]) && $stable(dest_q[0]))); // R6
   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q != '0) && (len_q <= LEN_W'(MAX_ENTRIES))); // R7
endmodule

// File: rtl/tsr_walker.sv
module tsr_walker #(
   parameter int MAX_ENTRIES = 64,
   parameter int MAX_RUN     = 64,
   parameter int N_CHAN      = 5,
   localparam int IDX_W  = $clog2(MAX_ENTRIES),
   localparam int RUN_W  = $clog2(MAX_RUN + 1),
   localparam int DEST_W = $clog2(N_CHAN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              slot_stb_i,
   input  logic              frame_stb_i,
   input  logic [RUN_W-1:0]  ent_count_i,
   input  logic [DEST_W-1:0] ent_dest_i,
   input  logic [IDX_W-1:0]  last_idx_i,
   output logic [IDX_W-1:0]  rd_idx_o,
   output logic [DEST_W-1:0] dest_o,
   output logic [N_CHAN-1:0] valid_o
);
   logic [IDX_W-1:0]  ptr_q;
   logic [RUN_W-1:0]  used_q;
   logic              done_q;

   logic              restart;
   logic [RUN_W-1:0]  used_eff;
   logic              live;
   logic [DEST_W-1:0] slot_dest;
   logic [N_CHAN-1:0] valid_d;

   assign restart  = slot_stb_i && frame_stb_i;
   assign rd_idx_o = restart ? '0 : ptr_q;
   assign used_eff = restart ? '0 : used_q;
   assign live     = restart || !done_q;
   assign slot_dest = live ? ent_dest_i : '0;

   always_comb begin
      for (int c = 0; c < N_CHAN; c++)
         valid_d[c] = enable_i && slot_stb_i && (slot_dest == DEST_W'(c + 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         used_q  <= '0;
         done_q  <= 1'b1;
         dest_o  <= '0;
         valid_o <= '0;
      end else if (!enable_i) begin
         ptr_q   <= '0;
         used_q  <= '0;
         done_q  <= 1'b1;
         dest_o  <= '0;
         valid_o <= '0;
      end else begin
         valid_o <= valid_d;
         if (slot_stb_i) begin
            dest_o <= slot_dest;
            if (live) begin
               if (used_eff + RUN_W'(1) == ent_count_i) begin
                  used_q <= '0;
                  if (rd_idx_o == last_idx_i) begin
                     done_q <= 1'b1;
                     ptr_q  <= '0;
                  end else begin
                     done_q <= 1'b0;
                     ptr_q  <= rd_idx_o + IDX_W'(1);
                  end
               end else begin
                  done_q <= 1'b0;
                  ptr_q  <= rd_idx_o;
                  used_q <= used_eff + RUN_W'(1);
               end
            end
         end
      end
   end

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (dest_o == '0 && valid_o == '0)); // R1
   AST_DEST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      dest_o <= DEST_W'(N_CHAN)); // R2
   AST_FRAME_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && restart) |=> (done_q || ptr_q <= IDX_W'(1))); // R3
   AST_VALID_MATCHES_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o != '0) |-> (dest_o != '0 && valid_o == (N_CHAN'(1) << (dest_o - DEST_W'(1))))); // R4
   AST_PTR_IN_LIST: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> (ptr_q <= last_idx_i)); // R5
   AST_VALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(valid_o)); // R10
   AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o != '0) |-> $past(slot_stb_i && enable_i)); // R10
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router #(
   parameter int MAX_ENTRIES = 64,
   parameter int MAX_RUN     = 64,
   parameter int N_CHAN      = 5,
   parameter int FLAG_W      = 4,
   localparam int IDX_W  = $clog2(MAX_ENTRIES),
   localparam int RUN_W  = $clog2(MAX_RUN + 1),
   localparam int LEN_W  = $clog2(MAX_ENTRIES + 1),
   localparam int DEST_W = $clog2(N_CHAN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tx_slot_stb,
   input  logic              tx_frame_stb,
   input  logic              rx_slot_stb,
   input  logic              rx_frame_stb,
   input  logic              wr_en,
   input  logic              wr_dir,
   input  logic              wr_kind,
   input  logic [IDX_W-1:0]  wr_addr,
   input  logic [RUN_W-1:0]  wr_count,
   input  logic [DEST_W-1:0] wr_dest,
   input  logic [FLAG_W-1:0] wr_flags,
   input  logic [LEN_W-1:0]  wr_len,
   output logic [DEST_W-1:0] tx_dest,
   output logic [N_CHAN-1:0] tx_valid,
   output logic [DEST_W-1:0] rx_dest,
   output logic [N_CHAN-1:0] rx_valid
);
   import tsr_pkg::*;

   if (MAX_ENTRIES < 2) begin : g_bad_entries
      $error("MAX_ENTRIES must be at least 2");
   end
   if (MAX_RUN < 1) begin : g_bad_run
      $error("MAX_RUN must be at least 1");
   end
   if (N_CHAN < 1) begin : g_bad_chan
      $error("N_CHAN must be at least 1");
   end
   if (FLAG_W < 1) begin : g_bad_flags
      $error("FLAG_W must be at least 1");
   end

   logic              slot_stb  [N_DIR];
   logic              frame_stb [N_DIR];
   logic [DEST_W-1:0] dest_w    [N_DIR];
   logic [N_CHAN-1:0] valid_w   [N_DIR];

   assign slot_stb[DIR_TX]  = tx_slot_stb;
   assign slot_stb[DIR_RX]  = rx_slot_stb;
   assign frame_stb[DIR_TX] = tx_frame_stb;
   assign frame_stb[DIR_RX] = rx_frame_stb;

   for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      logic [IDX_W-1:0]  rd_idx;
      logic [RUN_W-1:0]  ent_count;
      logic [DEST_W-1:0] ent_dest;
      logic [IDX_W-1:0]  last_idx;
      logic              dir_wr;

      assign dir_wr = wr_en && (wr_dir == 1'(d));

      tsr_route_table #(
         .MAX_ENTRIES (MAX_ENTRIES),
         .MAX_RUN     (MAX_RUN),
         .N_CHAN      (N_CHAN),
         .FLAG_W      (FLAG_W)
      ) u_table (
         .clk        (clk),
         .rst_n      (rst_n),
         .enable_i   (enable),
         .wr_en_i    (dir_wr),
         .wr_kind_i  (wr_kind),
         .wr_addr_i  (wr_addr),
         .wr_count_i (wr_count),
         .wr_dest_i  (wr_dest),
         .wr_flags_i (wr_flags),
         .wr_len_i   (wr_len),
         .rd_idx_i   (rd_idx),
         .rd_count_o (ent_count),
         .rd_dest_o  (ent_dest),
         .last_idx_o (last_idx)
      );

      tsr_walker #(
         .MAX_ENTRIES (MAX_ENTRIES),
         .MAX_RUN     (MAX_RUN),
         .N_CHAN      (N_CHAN)
      ) u_walk (
         .clk         (clk),
         .rst_n       (rst_n),
         .enable_i    (enable),
         .slot_stb_i  (slot_stb[d]),
         .frame_stb_i (frame_stb[d]),
         .ent_count_i (ent_count),
         .ent_dest_i  (ent_dest),
         .last_idx_i  (last_idx),
         .rd_idx_o    (rd_idx),
         .dest_o      (dest_w[d]),
         .valid_o     (valid_w[d])
      );
   end

   assign tx_dest  = dest_w[DIR_TX];
   assign tx_valid = valid_w[DIR_TX];
   assign rx_dest  = dest_w[DIR_RX];
   assign rx_valid = valid_w[DIR_RX];

   AST_DIR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_slot_stb && enable) |=> (tx_valid == '0)); // R8
endmodule

// File: tb/tb_tdm_slot_router.sv
module tb_tdm_slot_router;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       tx_slot_stb = 0, tx_frame_stb = 0, rx_slot_stb = 0, rx_frame_stb = 0;
   logic       wr_en = 0, wr_dir = 0, wr_kind = 0;
   logic [5:0] wr_addr = '0;
   logic [6:0] wr_count = '0;
   logic [2:0] wr_dest = '0;
   logic [3:0] wr_flags = '0;
   logic [6:0] wr_len = '0;
   logic [2:0] tx_dest, rx_dest;
   logic [4:0] tx_valid, rx_valid;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   // bench model of both lists: [dir][entry]
   int m_cnt [2][64];
   int m_dst [2][64];
   int m_len [2];
   bit framed [2];
   int sidx [2];

   always #4 clk = ~clk;

   tdm_slot_router dut (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .tx_slot_stb(tx_slot_stb), .tx_frame_stb(tx_frame_stb),
      .rx_slot_stb(rx_slot_stb), .rx_frame_stb(rx_frame_stb),
      .wr_en(wr_en), .wr_dir(wr_dir), .wr_kind(wr_kind), .wr_addr(wr_addr),
      .wr_count(wr_count), .wr_dest(wr_dest), .wr_flags(wr_flags), .wr_len(wr_len),
      .tx_dest(tx_dest), .tx_valid(tx_valid), .rx_dest(rx_dest), .rx_valid(rx_valid)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_of(input int d, input int idx);
      int acc = 0;
      if (!framed[d]) return 0;
      for (int e = 0; e < m_len[d]; e++) begin
         if (idx < acc + m_cnt[d][e]) return m_dst[d][e];
         acc += m_cnt[d][e];
      end
      return 0;
   endfunction

   function automatic int onehot(input int dst);
      return (dst == 0) ? 0 : (1 << (dst - 1));
   endfunction

   task automatic wr_entry(input int d, input int addr, input int cnt, input int dst, input int flg);
      @(negedge clk);
      wr_en = 1; wr_dir = d[0]; wr_kind = 0; wr_addr = addr[5:0];
      wr_count = cnt[6:0]; wr_dest = dst[2:0]; wr_flags = flg[3:0];
      @(posedge clk);
      if (!enable && flg == 0 && cnt >= 1 && cnt <= 64 && dst <= 5) begin
         m_cnt[d][addr] = cnt; m_dst[d][addr] = dst;
      end
      @(negedge clk);
      wr_en = 0; wr_flags = 0;
   endtask

   task automatic wr_length(input int d, input int len);
      @(negedge clk);
      wr_en = 1; wr_dir = d[0]; wr_kind = 1; wr_len = len[6:0];
      @(posedge clk);
      if (!enable && len >= 1 && len <= 64) m_len[d] = len;
      @(negedge clk);
      wr_en = 0; wr_kind = 0;
   endtask

   task automatic set_enable(input bit en);
      @(negedge clk);
      enable = en;
      framed[0] = 0; framed[1] = 0;
      @(negedge clk);
   endtask

   // one slot on the chosen directions; checks the outputs after the sampling edge
   task automatic slot(input bit tx, input bit txf, input bit rx, input bit rxf, input string req);
      int et = 0, er = 0;
      if (tx) begin
         if (txf) begin framed[0] = 1; sidx[0] = 0; end
         et = enable ? exp_of(0, sidx[0]) : 0;
         sidx[0]++;
      end
      if (rx) begin
         if (rxf) begin framed[1] = 1; sidx[1] = 0; end
         er = enable ? exp_of(1, sidx[1]) : 0;
         sidx[1]++;
      end
      // negedge already current
      tx_slot_stb = tx; tx_frame_stb = txf; rx_slot_stb = rx; rx_frame_stb = rxf;
      @(posedge clk);
      @(negedge clk);
      tx_slot_stb = 0; tx_frame_stb = 0; rx_slot_stb = 0; rx_frame_stb = 0;
      if (tx) begin
         chk(tx_dest == et[2:0], req, tx_dest, et);
         chk(tx_valid == 5'(onehot(et)), req, tx_valid, onehot(et));
      end
      if (rx) begin
         chk(rx_dest == er[2:0], req, rx_dest, er);
         chk(rx_valid == 5'(onehot(er)), req, rx_valid, onehot(er));
      end
   endtask

   task automatic t_reset();
      chk(tx_dest == 0 && rx_dest == 0, "R1 reset dest", {tx_dest, rx_dest}, 0);
      chk(tx_valid == 0 && rx_valid == 0, "R1 reset valid", {tx_valid, rx_valid}, 0);
      // disabled: strobes give nothing
      slot(1, 1, 1, 1, "R1 disabled");
      set_enable(1);
      for (int i = 0; i < 3; i++) slot(1, i == 0, 1, i == 0, "R1 default list");
      set_enable(0);
   endtask

   task automatic t_example();
      wr_entry(0, 0, 2, 0, 0); wr_entry(0, 1, 24, 3, 0);
      wr_entry(0, 2, 1, 0, 0); wr_entry(0, 3, 5, 2, 0);
      wr_length(0, 4);
      wr_entry(1, 0, 3, 1, 0); wr_entry(1, 1, 4, 5, 0); wr_entry(1, 2, 1, 4, 0);
      wr_length(1, 3);
      set_enable(1);
      for (int i = 0; i < 34; i++) slot(1, i == 0, 1, i == 0, "R4 R8 R5 run-length frame");
      // pulse lasts one cycle
      @(negedge clk);
      chk(tx_valid == 0 && rx_valid == 0, "R10 pulse width", {tx_valid, rx_valid}, 0);
      // only rx strobes: tx holds, tx valid stays low
      for (int i = 0; i < 3; i++) begin
         slot(0, 0, 1, i == 0, "R8 rx alone");
         chk(tx_valid == 0, "R8 tx quiet", tx_valid, 0);
      end
      set_enable(0);
   endtask

   task automatic t_restart();
      set_enable(1);
      for (int i = 0; i < 5; i++) slot(1, i == 0, 0, 0, "R3 pre-restart");
      slot(1, 1, 0, 0, "R3 mid-frame restart");
      for (int i = 0; i < 3; i++) slot(1, 0, 0, 0, "R3 after restart");
      // frame mark alone ignored
      @(negedge clk);
      tx_frame_stb = 1;
      @(negedge clk);
      tx_frame_stb = 0;
      for (int i = 0; i < 2; i++) slot(1, 0, 0, 0, "R9 lone frame mark");
      set_enable(0);
   endtask

   task automatic t_no_frame();
      set_enable(1);
      for (int i = 0; i < 3; i++) slot(1, 0, 1, 0, "R5 before first frame");
      set_enable(0);
   endtask

   task automatic t_locked();
      set_enable(1);
      wr_entry(0, 1, 1, 5, 0);
      wr_length(0, 1);
      for (int i = 0; i < 6; i++) slot(1, i == 0, 0, 0, "R6 write while enabled");
      set_enable(0);
   endtask

   task automatic t_reject();
      wr_entry(0, 1, 24, 4, 1);
      wr_entry(0, 0, 0, 1, 0);
      wr_entry(0, 0, 65, 1, 0);
      wr_entry(0, 3, 5, 6, 0);
      wr_length(0, 0);
      wr_length(0, 65);
      set_enable(1);
      for (int i = 0; i < 33; i++) slot(1, i == 0, 0, 0, "R7 illegal writes");
      set_enable(0);
   endtask

   task automatic t_full();
      for (int e = 0; e < 64; e++) wr_entry(1, e, 1, (e % 5) + 1, 0);
      wr_length(1, 64);
      wr_entry(0, 0, 64, 4, 0);
      wr_length(0, 1);
      set_enable(1);
      for (int i = 0; i < 66; i++) slot(1, i == 0, 1, i == 0, "R2 R5 full list");
      set_enable(0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      for (int d = 0; d < 2; d++) begin
         for (int e = 0; e < 64; e++) begin m_cnt[d][e] = 1; m_dst[d][e] = 0; end
         m_len[d] = 1; framed[d] = 0; sidx[d] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_example();
      t_restart();
      t_no_frame();
      t_locked();
      t_reject();
      t_full();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end
endmodule